// File: doc/BRIEF.md
# Multi-Size Translation Buffer with Zone-Based Access Control

This block is a fully associative address translation buffer. A requester presents a 32-bit virtual address with an access kind (load, store or instruction fetch), a privilege flag and the running process number. All stored entries are checked in parallel. The lowest-numbered matching entry decides the outcome, which is a miss, a protection fault or a hit with the translated physical address. Each entry describes a page of one of eight sizes, from 1 KiB to 16 MiB, so pages of different sizes can share the table. An entry may be private to one process or shared by all of them.

Each entry points at one of sixteen protection zones. A 32-bit zone control word gives every zone a 2-bit code. The code can hide the entry from user-mode requests, leave the entry's own write and execute bits in force, or raise those bits for supervisor-mode requests or for every request. Table contents are loaded through a single-entry write port. The lookup result comes out of a register one clock after the request.

Top module: `tlb_zone_xlate`

## Requirements
- R1: The page-size code in tag bits 9:7 selects a page of 2^(10+2*code) bytes, which gives 1K, 4K, 16K, 64K, 256K, 1M, 4M or 16M.
- R2: An entry takes part only when tag bit 6 (valid) is set and the virtual address equals the tag on every bit at or above log2 of the page size. If no entry takes part, the status is miss (0), with index 0, address 0 and both grants 0.
- R3: An entry whose 8-bit process tag is zero serves every process. A nonzero tag serves only the process whose `pid` equals it.
- R4: Data bits 7:4 hold the zone number z. The zone code is taken from control bits (31-2z):(30-2z), so zone 0 sits at the top of the word.
- R5: Zone code 0 hides the entry from user requests (`user`=1), and the search moves on to later entries. Code 1 keeps the entry's own bits. Code 2 grants write and execute to supervisor requests only. Code 3 grants them to every request.
- R6: A zone number greater than NUM_ZONES is treated as code 1. With ZONES_EN=0, every entry is treated as code 1.
- R7: Loads (`acc`=0) never fault. A store (`acc`=1) without the effective write grant (own bit is data bit 8), or a fetch (`acc`=2) without the effective execute grant (own bit is data bit 9), ends the search with status fault (1), reporting that entry's index and grants with address 0.
- R8: The entry with the lowest index that takes part decides the result, even when a later entry would also match.
- R9: On a hit (status 2), the physical address is data bits 31:10 with ten zero bits below, ANDed with ADDR_MASK. The index and the effective grants are reported with it.
- R10: `rsp_valid` is high exactly in the cycle after a cycle with `req` high, and the result fields belong to that request.
- R11: A write strobe stores tag, data and process tag at `wr_idx`, and later lookups see the new entry. A `wr_idx` at or beyond ENTRIES changes nothing.
- R12: Reset clears every valid bit and drops `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Entry number to write |
| wr_tag | input | 32 | Tag word: page number, size code 9:7, valid bit 6 |
| wr_data | input | 32 | Data word: real page 31:10, execute 9, write 8, zone 7:4 |
| wr_tid | input | 8 | Process tag of the entry, 0 means shared |
| req | input | 1 | Lookup request strobe |
| va | input | 32 | Virtual address |
| acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| user | input | 1 | 1 for a user-mode request, 0 for supervisor |
| pid | input | 8 | Current process number |
| zpr | input | 32 | Zone control word, two bits per zone |
| rsp_valid | output | 1 | Result valid |
| rsp_status | output | 2 | 0 miss, 1 protection fault, 2 hit |
| rsp_idx | output | IDX_W | Deciding entry number |
| rsp_pa | output | 32 | Physical address |
| rsp_w | output | 1 | Effective write grant |
| rsp_x | output | 1 | Effective execute grant |

## Verification
Every lookup result is due exactly one clock after the cycle in which `req` is high. The bench drives each request on a falling edge and reads all result fields on the next falling edge, which is half a cycle after the capturing rising edge. It also checks that `rsp_valid` falls one clock after an idle cycle. A table write driven on a falling edge is in place at the next rising edge, so a lookup issued on the following falling edge already sees it. The bench keeps its own copy of the table and sweeps it over addresses at page edges, process numbers, privilege levels, access kinds and zone words. It runs a second instance with zones disabled.

// File: rtl/tlb_zone_pkg.sv
package tlb_zone_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    ST_MISS  = 2'd0,
    ST_FAULT = 2'd1,
    ST_HIT   = 2'd2
  } status_e;

  localparam int WORD_W    = 32;
  localparam int TID_W     = 8;
  localparam int PAGE_LSB  = 10;
  localparam int VALID_BIT = 6;

  // Mask that keeps the page-number bits for a given size code.
  function automatic logic [WORD_W-1:0] page_keep_mask(input logic [2:0] code);
    return {WORD_W{1'b1}} << (5'd10 + {1'b0, code, 1'b0});
  endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 8,
  parameter int SEL_W   = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [31:0]                 wr_tag,
  input  logic [31:0]                 wr_data,
  input  logic [7:0]                  wr_tid,
  output logic [ENTRIES-1:0][31:0]    tag_q,
  output logic [ENTRIES-1:0][31:0]    data_q,
  output logic [ENTRIES-1:0][7:0]     tid_q
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(ENTRIES);

  logic in_range;
  assign in_range = ({1'b0, wr_idx} < LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
    end else if (wr_en && in_range) begin
      tag_q[wr_idx[SEL_W-1:0]] <= wr_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && in_range) begin
      data_q[wr_idx[SEL_W-1:0]] <= wr_data;
      tid_q[wr_idx[SEL_W-1:0]]  <= wr_tid;
    end
  end

  // R11: an index past the table leaves every tag unchanged
  a_r11_range_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !in_range) |=> $stable(tag_q));

endmodule

// File: rtl/tlb_entry_eval.sv
module tlb_entry_eval
  import tlb_zone_pkg::*;
#(
  parameter int NUM_ZONES = 16,
  parameter bit ZONES_EN  = 1'b1
) (
  input  logic [31:0] tag,
  input  logic [9:4]  dattr,
  input  logic [7:0]  tid,
  input  logic [31:0] va,
  input  logic [1:0]  acc,
  input  logic        user,
  input  logic [7:0]  pid,
  input  logic [31:0] zpr,
  output logic        cand,
  output logic        eff_w,
  output logic        eff_x,
  output logic        fault
);
  localparam logic [4:0] ZLIM = 5'((NUM_ZONES > 31) ? 31 : NUM_ZONES);

  logic [31:0] keep;
  logic        addr_eq, tid_ok, hidden;
  logic [3:0]  zsel;
  logic [4:0]  zshift;
  logic [31:0] zword;
  logic [1:0]  zcode;

  always_comb begin
    keep    = page_keep_mask(tag[9:7]);
    addr_eq = ((va ^ tag) & keep) == '0;
    tid_ok  = (tid == '0) || (tid == pid);
    zsel    = dattr[7:4];
    zshift  = 5'd30 - {zsel, 1'b0};
    zword   = zpr >> zshift;
    if (!ZONES_EN || ({1'b0, zsel} > ZLIM)) zcode = 2'd1;
    else                                    zcode = zword[1:0];
    hidden  = (zcode == 2'd0) && user;
    cand    = tag[VALID_BIT] && addr_eq && tid_ok && !hidden;
    eff_w   = dattr[8] || (zcode == 2'd3) || ((zcode == 2'd2) && !user);
    eff_x   = dattr[9] || (zcode == 2'd3) || ((zcode == 2'd2) && !user);
    fault   = ((acc == ACC_STORE) && !eff_w) || ((acc == ACC_FETCH) && !eff_x);
  end

endmodule

// File: rtl/tlb_first_pick.sv
module tlb_first_pick #(
  parameter int ENTRIES = 64,
  parameter int SEL_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] cand,
  output logic               found,
  output logic [SEL_W-1:0]   sel
);
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (cand[i] && !found) begin
        found = 1'b1;
        sel   = SEL_W'(i);
      end
    end
  end

  logic [ENTRIES-1:0] below;
  assign below = (ENTRIES'(1) << sel) - ENTRIES'(1);

  // R8: the chosen entry is a candidate and none below it is
  a_r8_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    found |-> (cand[sel] && ((cand & below) == '0)));
  a_r8_none_found: assert property (@(posedge clk) disable iff (rst)
    !found |-> (cand == '0));

endmodule

// File: rtl/tlb_zone_xlate.sv
module tlb_zone_xlate
  import tlb_zone_pkg::*;
#(
  parameter int          ENTRIES   = 64,
  parameter int          IDX_W     = 8,
  parameter int          NUM_ZONES = 16,
  parameter bit          ZONES_EN  = 1'b1,
  parameter logic [31:0] ADDR_MASK = 32'hFFFF_FFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_tag,
  input  logic [31:0]      wr_data,
  input  logic [7:0]       wr_tid,
  input  logic             req,
  input  logic [31:0]      va,
  input  logic [1:0]       acc,
  input  logic             user,
  input  logic [7:0]       pid,
  input  logic [31:0]      zpr,
  output logic             rsp_valid,
  output logic [1:0]       rsp_status,
  output logic [IDX_W-1:0] rsp_idx,
  output logic [31:0]      rsp_pa,
  output logic             rsp_w,
  output logic             rsp_x
);
  localparam int SEL_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(ENTRIES);

  logic [ENTRIES-1:0][31:0] tag_q, data_q;
  logic [ENTRIES-1:0][7:0]  tid_q;
  logic [ENTRIES-1:0]       cand, eff_w, eff_x, fault;
  logic                     found;
  logic [SEL_W-1:0]         sel;
  logic [31:0]              win_data;
  logic [1:0]               acc_q;
  logic                     unused_low;

  tlb_entry_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_tag(wr_tag), .wr_data(wr_data), .wr_tid(wr_tid),
    .tag_q(tag_q), .data_q(data_q), .tid_q(tid_q)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    tlb_entry_eval #(.NUM_ZONES(NUM_ZONES), .ZONES_EN(ZONES_EN)) u_eval (
      .tag(tag_q[g]), .dattr(data_q[g][9:4]), .tid(tid_q[g]),
      .va(va), .acc(acc), .user(user), .pid(pid), .zpr(zpr),
      .cand(cand[g]), .eff_w(eff_w[g]), .eff_x(eff_x[g]), .fault(fault[g])
    );
  end

  tlb_first_pick #(.ENTRIES(ENTRIES), .SEL_W(SEL_W)) u_pick (
    .clk(clk), .rst(rst), .cand(cand), .found(found), .sel(sel)
  );

  assign win_data   = data_q[sel];
  assign unused_low = ^win_data[3:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_MISS;
      rsp_idx    <= '0;
      rsp_pa     <= '0;
      rsp_w      <= 1'b0;
      rsp_x      <= 1'b0;
      acc_q      <= ACC_LOAD;
    end else begin
      rsp_valid <= req;
      if (req) begin
        acc_q <= acc;
        if (!found) begin
          rsp_status <= ST_MISS;
          rsp_idx    <= '0;
          rsp_pa     <= '0;
          rsp_w      <= 1'b0;
          rsp_x      <= 1'b0;
        end else begin
          rsp_idx <= IDX_W'(sel);
          rsp_w   <= eff_w[sel];
          rsp_x   <= eff_x[sel];
          if (fault[sel]) begin
            rsp_status <= ST_FAULT;
            rsp_pa     <= '0;
          end else begin
            rsp_status <= ST_HIT;
            rsp_pa     <= {win_data[31:PAGE_LSB], {PAGE_LSB{1'b0}}} & ADDR_MASK;
          end
        end
      end
    end
  end

  // R10: one result per request, one clock later
  a_r10_result_follows: assert property (@(posedge clk) disable iff (rst)
    req |=> rsp_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req |=> !rsp_valid);
  // R7: loads never fault; a store or fetch that hits holds the grant
  a_r7_load_no_fault: assert property (@(posedge clk) disable iff (rst)
    (req && acc == ACC_LOAD) |=> (rsp_status != ST_FAULT));
  a_r7_store_hit_w: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == ST_HIT && acc_q == ACC_STORE) |-> rsp_w);
  a_r7_fetch_hit_x: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == ST_HIT && acc_q == ACC_FETCH) |-> rsp_x);
  // R2: a reported entry number lies inside the table
  a_r2_idx_in_table: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != ST_MISS) |-> ({1'b0, rsp_idx} < LIMIT));

endmodule

// File: tb/tb_tlb_zone_xlate.sv
`timescale 1ns/1ps
module tb_tlb_zone_xlate;
  localparam int          N    = 8;
  localparam int          IW   = 8;
  localparam int          NZ   = 8;
  localparam logic [31:0] AMSK = 32'h0FFF_FFFF;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst, wr_en, req, user;
  logic [IW-1:0] wr_idx;
  logic [31:0]   wr_tag, wr_data, va, zpr;
  logic [7:0]    wr_tid, pid;
  logic [1:0]    acc;
  logic          v1, v2, w1, w2, x1, x2;
  logic [1:0]    s1, s2;
  logic [IW-1:0] i1, i2;
  logic [31:0]   p1, p2;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  tlb_zone_xlate #(.ENTRIES(N), .IDX_W(IW), .NUM_ZONES(NZ), .ZONES_EN(1'b1), .ADDR_MASK(AMSK)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_data(wr_data), .wr_tid(wr_tid), .req(req), .va(va), .acc(acc),
    .user(user), .pid(pid), .zpr(zpr), .rsp_valid(v1), .rsp_status(s1),
    .rsp_idx(i1), .rsp_pa(p1), .rsp_w(w1), .rsp_x(x1));

  tlb_zone_xlate #(.ENTRIES(N), .IDX_W(IW), .NUM_ZONES(NZ), .ZONES_EN(1'b0), .ADDR_MASK(AMSK)) dut_nz (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_data(wr_data), .wr_tid(wr_tid), .req(req), .va(va), .acc(acc),
    .user(user), .pid(pid), .zpr(zpr), .rsp_valid(v2), .rsp_status(s2),
    .rsp_idx(i2), .rsp_pa(p2), .rsp_w(w2), .rsp_x(x2));

  // Bench copy of the table
  logic [31:0] m_tag  [N];
  logic [31:0] m_data [N];
  logic [7:0]  m_tid  [N];

  function automatic logic [31:0] pg_size(input logic [2:0] c);
    return 32'd1 << (10 + 2 * int'(c));
  endfunction

  task automatic model(input logic [31:0] a, input logic [1:0] k, input logic u,
                       input logic [7:0] p, input logic [31:0] z, input bit zen,
                       output logic [1:0] st, output logic [IW-1:0] ix,
                       output logic [31:0] pa, output logic w, output logic x);
    st = 2'd0; ix = '0; pa = '0; w = 1'b0; x = 1'b0;
    for (int i = 0; i < N; i++) begin
      logic [31:0] sz;
      int          zs;
      logic [1:0]  zc;
      logic        ew, ex;
      if (!m_tag[i][6]) continue;
      sz = pg_size(m_tag[i][9:7]);
      if ((a & ~(sz - 1)) != (m_tag[i] & ~(sz - 1))) continue;
      if (m_tid[i] != 8'd0 && m_tid[i] != p) continue;
      zs = int'(m_data[i][7:4]);
      zc = z[31 - 2*zs -: 2];
      if (!zen || zs > NZ) zc = 2'd1;
      if (zc == 2'd0 && u) continue;
      ew = m_data[i][8] || zc == 2'd3 || (zc == 2'd2 && !u);
      ex = m_data[i][9] || zc == 2'd3 || (zc == 2'd2 && !u);
      ix = IW'(i); w = ew; x = ex;
      if ((k == 2'd1 && !ew) || (k == 2'd2 && !ex)) begin
        st = 2'd1;
      end else begin
        st = 2'd2;
        pa = {m_data[i][31:10], 10'b0} & AMSK;
      end
      return;
    end
  endtask

  task automatic bad(input string rq, input string what, input logic [31:0] got, input logic [31:0] exp);
    fails++;
    $display("FAIL %s %s: actual %h expected %h", rq, what, got, exp);
  endtask

  task automatic tbl_write(input int i, input logic [31:0] t, input logic [31:0] d, input logic [7:0] id);
    wr_en = 1'b1; wr_idx = IW'(i); wr_tag = t; wr_data = d; wr_tid = id;
    if (i < N) begin m_tag[i] = t; m_data[i] = d; m_tid[i] = id; end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] mk_tag(input logic [31:0] base, input logic [2:0] c, input logic vld);
    return (base & ~(pg_size(c) - 1)) | (32'(c) << 7) | (32'(vld) << 6);
  endfunction

  function automatic logic [31:0] mk_data(input logic [31:0] rpn, input logic x, input logic w, input logic [3:0] z);
    return (rpn & 32'hFFFF_FC00) | (32'(x) << 9) | (32'(w) << 8) | (32'(z) << 4);
  endfunction

  // Issue one lookup on a falling edge, compare both instances on the next one
  task automatic look(input logic [31:0] a, input logic [1:0] k, input logic u,
                      input logic [7:0] p, input logic [31:0] z, input string rq);
    logic [1:0] es; logic [IW-1:0] ei; logic [31:0] ep; logic ew, ex;
    req = 1'b1; va = a; acc = k; user = u; pid = p; zpr = z;
    @(negedge clk);
    req = 1'b0;
    model(a, k, u, p, z, 1'b1, es, ei, ep, ew, ex);
    checks++;
    if (v1 !== 1'b1)  bad("R10", "valid", 32'(v1), 32'd1);
    else if (s1 !== es) bad(rq, "status", 32'(s1), 32'(es));
    else if (i1 !== ei) bad(rq, "index", 32'(i1), 32'(ei));
    else if (p1 !== ep) bad(rq, "paddr", p1, ep);
    else if (w1 !== ew || x1 !== ex) bad(rq, "grants", {30'b0, w1, x1}, {30'b0, ew, ex});
    model(a, k, u, p, z, 1'b0, es, ei, ep, ew, ex);
    checks++;
    if (s2 !== es || i2 !== ei || p2 !== ep || w2 !== ew || x2 !== ex)
      bad("R6", "zones-off result", {s2, 6'b0, i2, 14'b0, w2, x2}, {es, 6'b0, ei, 14'b0, ew, ex});
  endtask

  logic [31:0] zpats [6];

  // Covers R1 R2 R3 R4 R5 R7 R8 R9 through page edges, pid, mode, kind and zone word
  task automatic sweep();
    for (int e = 0; e < N; e++) begin
      for (int q = 0; q < 4; q++) begin
        logic [31:0] sz, base, a;
        sz   = pg_size(m_tag[e][9:7]);
        base = m_tag[e] & ~(sz - 1);
        case (q)
          0: a = base;
          1: a = base + sz - 1;
          2: a = base + sz;
          default: a = base ^ 32'h0000_0200;
        endcase
        for (int pi = 0; pi < 4; pi++) begin
          logic [7:0] p;
          p = (pi == 0) ? 8'd0 : (pi == 1) ? 8'd5 : (pi == 2) ? 8'd9 : 8'd3;
          for (int u = 0; u < 2; u++)
            for (int k = 0; k < 3; k++)
              for (int zi = 0; zi < 6; zi++)
                look(a, 2'(k), u[0], p, zpats[zi], "R1/R2/R3/R4/R5/R7/R8/R9");
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog expired: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    zpats[0] = 32'h0000_0000; zpats[1] = 32'h5555_5555; zpats[2] = 32'hAAAA_AAAA;
    zpats[3] = 32'hFFFF_FFFF; zpats[4] = 32'h1B1B_1B1B; zpats[5] = 32'hE4E4_E4E4;
    for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_data[i] = '0; m_tid[i] = '0; end
    rst = 1'b1; wr_en = 1'b0; req = 1'b0; wr_idx = '0; wr_tag = '0; wr_data = '0;
    wr_tid = '0; va = '0; acc = '0; user = 1'b0; pid = '0; zpr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12: reset state
    checks++;
    if (v1 !== 1'b0) bad("R12", "valid after reset", 32'(v1), 32'd0);
    look(32'h0001_0000, 2'd0, 1'b0, 8'd0, 32'h0, "R12");
    // R11: an out-of-table index is dropped
    tbl_write(200, mk_tag(32'hFFFF_F000, 3'd1, 1'b1), mk_data(32'h1, 1'b1, 1'b1, 4'd0), 8'd0);
    look(32'hFFFF_F000, 2'd0, 1'b0, 8'd0, 32'h0, "R11");
    checks++;
    if (s1 !== 2'd0) bad("R11", "status after bad index", 32'(s1), 32'd0);

    tbl_write(0, mk_tag(32'h0001_0000, 3'd1, 1'b1), mk_data(32'hF000_1000, 1'b0, 1'b0, 4'd1), 8'd5);
    tbl_write(1, mk_tag(32'h0100_0000, 3'd7, 1'b1), mk_data(32'h1200_0000, 1'b0, 1'b1, 4'd2), 8'd0);
    tbl_write(2, mk_tag(32'h0001_0400, 3'd0, 1'b1), mk_data(32'h0000_2400, 1'b1, 1'b0, 4'd0), 8'd0);
    tbl_write(3, mk_tag(32'h0002_0000, 3'd3, 1'b1), mk_data(32'h3003_0000, 1'b1, 1'b1, 4'd12), 8'd9);
    tbl_write(4, mk_tag(32'h0004_0000, 3'd4, 1'b1), mk_data(32'hC004_0000, 1'b0, 1'b0, 4'd3), 8'd0);
    tbl_write(5, mk_tag(32'h0010_0000, 3'd5, 1'b0), mk_data(32'h0050_0000, 1'b1, 1'b1, 4'd5), 8'd0);
    tbl_write(6, mk_tag(32'h0040_0000, 3'd6, 1'b1), mk_data(32'h0660_0000, 1'b0, 1'b1, 4'd7), 8'd0);
    tbl_write(7, mk_tag(32'h0001_0000, 3'd0, 1'b1), mk_data(32'h0770_0000, 1'b1, 1'b0, 4'd8), 8'd0);

    // R10: no result follows an idle cycle
    @(negedge clk);
    checks++;
    if (v1 !== 1'b0) bad("R10", "valid when idle", 32'(v1), 32'd0);

    sweep();
    // R11: rewrite entries and sweep again
    tbl_write(0, mk_tag(32'h0001_0000, 3'd1, 1'b0), mk_data(32'hF000_1000, 1'b0, 1'b0, 4'd1), 8'd5);
    tbl_write(3, mk_tag(32'h0002_0000, 3'd3, 1'b1), mk_data(32'h3003_0000, 1'b0, 1'b1, 4'd6), 8'd0);
    sweep();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule